// File: doc/BRIEF.md
# Bus clock prescaler

This block turns one main clock into four synchronous clock domains: the core (CPU), the high-speed bus, and two peripheral buses (A and B). Each domain is delivered as a single-cycle enable strobe, not as a derived clock. A domain either runs at the main rate or is divided by a power of two. Every domain also has a per-module mask. It produces one gated enable per module, so a module sees its domain strobe only while its mask bit is set.

Software programs the block through a plain write port. Address 0 holds the combined select word for all four domains. Addresses 4 to 7 take single-bit mask edits for domains 0 to 3. A select word that would leave a slower domain ahead of its parent is refused, and an error flag is raised.

An accepted select word does not take effect at once. It is held pending in a two-state update machine, with states UPD_IDLE and UPD_WAIT. Transition ACCEPT (UPD_IDLE to UPD_WAIT) fires on an accepted select write. Transition RELOAD (UPD_WAIT to UPD_WAIT) replaces the pending word when another accepted write arrives. Transition APPLY (UPD_WAIT to UPD_IDLE) fires when the shared phase counter wraps. At that wrap the pending word becomes active, so no domain ever sees a shortened strobe period.

Top module: `bus_clk_prescaler`

## Requirements
- R1: After reset every domain strobe is high on every cycle, every module enable is high (all mask bits set), and cfg_err is low.
- R2: The select word is written at address 0. Domain d (0 core, 1 high-speed bus, 2 peripheral A, 3 peripheral B) uses bits [4d+2:4d] as its select value SEL and bit 4d+3 as its divide enable.
- R3: A domain whose divide enable is clear strobes on every cycle. One whose divide enable is set strobes once every 2^(SEL+1) cycles, on counter phases that are multiples of that period; the range is 2 to 256.
- R4: With shift = SEL+1 when divide is enabled and 0 otherwise, a select word is legal only if shift(core) <= shift(high-speed) <= shift(peripheral A) and shift(high-speed) <= shift(peripheral B).
- R5: An illegal select write changes neither the active nor the pending setting and sets cfg_err. cfg_err stays set until the next legal select write, which clears it.
- R6: An 8-bit phase counter starts at 0 after reset and counts every cycle. An accepted setting becomes active only when the counter wraps from 255 to 0. A later legal write before that wrap replaces the pending one. A write accepted in the wrap cycle itself waits for the following wrap.
- R7: mod_en[8d+i] is high exactly when mask bit i of domain d is set and dom_stb[d] is high.
- R8: A write to address 4+d sets mask bit wr_data[2:0] of domain d to wr_data[15], starting the next cycle. All other mask bits are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 select word, 4..7 mask edit |
| wr_data | input | 16 | Write data |
| dom_stb | output | 4 | Per-domain enable strobe |
| mod_en | output | 32 | Per-module gated enables, 8 per domain |
| cfg_err | output | 1 | Last select write was refused |

## Verification
The undivided reset state and an all-disabled word confirm that clear divide-enable bits give full rate. A mixed ladder (2, 4, 8 and 4 cycles) and an all-256 word separate the four domains from one another and exercise the longest period. Two illegal words, one breaking each branch of the ordering rule, and a word with equal shifts at the legal edge, tell refusal apart from acceptance. The update timing is probed in three ways: a rewrite before the wrap, a write placed exactly in the wrap cycle, and single-bit mask clears and sets against active division, which show that neighbouring bits and other domains stay untouched.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
    localparam int NUM_DOM   = 4;
    localparam int MASK_BASE = 4;

    typedef enum logic [1:0] {
        DOM_CORE = 2'd0,
        DOM_FAST = 2'd1,
        DOM_PERA = 2'd2,
        DOM_PERB = 2'd3
    } dom_e;

    typedef enum logic {
        UPD_IDLE = 1'b0,
        UPD_WAIT = 1'b1
    } upd_state_e;
endpackage

// File: rtl/bcp_sel_ctrl.sv
module bcp_sel_ctrl
    import bcp_pkg::*;
#(
    parameter  int SEL_W     = 3,
    parameter  int ADDR_W    = 3,
    parameter  int DATA_W    = 16,
    localparam int FLD_W     = SEL_W + 1,
    localparam int WORD_W    = NUM_DOM * FLD_W,
    localparam int MAX_SHIFT = 1 << SEL_W,
    localparam int SH_W      = $clog2(MAX_SHIFT + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [WORD_W-1:0]                sel_word,
    input  logic                             at_wrap,
    output logic [NUM_DOM-1:0][SH_W-1:0]     act_shift,
    output logic                             cfg_err
);
    upd_state_e                      state_q, state_d;
    logic [NUM_DOM-1:0][SH_W-1:0]    req_shift;
    logic [NUM_DOM-1:0][SH_W-1:0]    pend_q;
    logic                            sel_wr, order_ok, accept, apply;

    assign sel_wr = wr_en && (wr_addr == '0);

    // decode each domain's field into a shift amount
    always_comb begin
        for (int d = 0; d < NUM_DOM; d++) begin
            if (sel_word[d*FLD_W + SEL_W])
                req_shift[d] = SH_W'(sel_word[d*FLD_W +: SEL_W]) + SH_W'(1);
            else
                req_shift[d] = '0;
        end
    end

    // no child domain may run faster than its parent
    assign order_ok = (req_shift[int'(DOM_CORE)] <= req_shift[int'(DOM_FAST)]) &&
                      (req_shift[int'(DOM_FAST)] <= req_shift[int'(DOM_PERA)]) &&
                      (req_shift[int'(DOM_FAST)] <= req_shift[int'(DOM_PERB)]);
    assign accept   = sel_wr && order_ok;

    // next-state and output decode
    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        unique case (state_q)
            UPD_IDLE: begin
                if (accept) state_d = UPD_WAIT;           // ACCEPT
            end
            UPD_WAIT: begin
                apply = at_wrap;
                if (at_wrap && !accept) state_d = UPD_IDLE; // APPLY
                // otherwise RELOAD or keep waiting
            end
            default: state_d = UPD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    // pending, active and error registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            act_shift <= '0;
            cfg_err   <= 1'b0;
        end else begin
            if (apply)  act_shift <= pend_q;
            if (accept) pend_q    <= req_shift;
            if (sel_wr) cfg_err   <= !order_ok;
        end
    end
endmodule

// File: rtl/bcp_phase_gen.sv
module bcp_phase_gen
    import bcp_pkg::*;
#(
    parameter  int SEL_W     = 3,
    localparam int MAX_SHIFT = 1 << SEL_W,
    localparam int CNT_W     = MAX_SHIFT,
    localparam int SH_W      = $clog2(MAX_SHIFT + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_DOM-1:0][SH_W-1:0] act_shift,
    output logic [NUM_DOM-1:0]           dom_stb,
    output logic                         at_wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] all_ones;

    assign all_ones = '1;
    assign at_wrap  = &cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic [CNT_W-1:0] low_mask;
        assign low_mask   = ~(all_ones << act_shift[d]);
        assign dom_stb[d] = ~|(cnt_q & low_mask);
    end
endmodule

// File: rtl/bcp_mod_gate.sv
module bcp_mod_gate
    import bcp_pkg::*;
#(
    parameter  int NUM_MOD = 8,
    parameter  int ADDR_W  = 3,
    localparam int IDX_W   = $clog2(NUM_MOD)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [IDX_W-1:0]            bit_idx,
    input  logic                        bit_val,
    input  logic [NUM_DOM-1:0]          dom_stb,
    output logic [NUM_DOM*NUM_MOD-1:0]  mod_en
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic [NUM_MOD-1:0] mask_q;
        logic               hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(MASK_BASE + d));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mask_q          <= '1;
            else if (hit) mask_q[bit_idx] <= bit_val;
        end

        assign mod_en[d*NUM_MOD +: NUM_MOD] = mask_q & {NUM_MOD{dom_stb[d]}};
    end
endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
    import bcp_pkg::*;
#(
    parameter  int SEL_W     = 3,
    parameter  int NUM_MOD   = 8,
    parameter  int ADDR_W    = 3,
    parameter  int DATA_W    = 16,
    localparam int FLD_W     = SEL_W + 1,
    localparam int WORD_W    = NUM_DOM * FLD_W,
    localparam int MAX_SHIFT = 1 << SEL_W,
    localparam int SH_W      = $clog2(MAX_SHIFT + 1),
    localparam int IDX_W     = $clog2(NUM_MOD)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NUM_DOM-1:0]          dom_stb,
    output logic [NUM_DOM*NUM_MOD-1:0]  mod_en,
    output logic                        cfg_err
);
    logic [NUM_DOM-1:0][SH_W-1:0] act_shift;
    logic                         at_wrap;

    bcp_sel_ctrl #(
        .SEL_W (SEL_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .sel_word (wr_data[WORD_W-1:0]),
        .at_wrap  (at_wrap),
        .act_shift(act_shift),
        .cfg_err  (cfg_err)
    );

    bcp_phase_gen #(
        .SEL_W(SEL_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_shift(act_shift),
        .dom_stb  (dom_stb),
        .at_wrap  (at_wrap)
    );

    bcp_mod_gate #(
        .NUM_MOD(NUM_MOD),
        .ADDR_W (ADDR_W)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .bit_idx(wr_data[IDX_W-1:0]),
        .bit_val(wr_data[DATA_W-1]),
        .dom_stb(dom_stb),
        .mod_en (mod_en)
    );
endmodule

// File: rtl/bcp_checker.sv
module bcp_checker
    import bcp_pkg::*;
#(
    parameter  int SEL_W     = 3,
    parameter  int NUM_MOD   = 8,
    parameter  int ADDR_W    = 3,
    parameter  int DATA_W    = 16,
    localparam int FLD_W     = SEL_W + 1,
    localparam int WORD_W    = NUM_DOM * FLD_W,
    localparam int MAX_SHIFT = 1 << SEL_W,
    localparam int SH_W      = $clog2(MAX_SHIFT + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [WORD_W-1:0]            wr_word,
    input logic [NUM_DOM-1:0]           dom_stb,
    input logic [NUM_DOM*NUM_MOD-1:0]   mod_en,
    input logic                         cfg_err,
    input logic [NUM_DOM-1:0][SH_W-1:0] act_shift,
    input logic                         at_wrap
);
    logic [NUM_DOM-1:0][SH_W-1:0] want;
    logic [NUM_DOM*NUM_MOD-1:0]   stb_wide;
    logic                         legal, sel_wr;

    always_comb begin
        for (int d = 0; d < NUM_DOM; d++) begin
            want[d] = wr_word[d*FLD_W + SEL_W] ?
                      SH_W'(wr_word[d*FLD_W +: SEL_W]) + SH_W'(1) : SH_W'(0);
            for (int i = 0; i < NUM_MOD; i++) stb_wide[d*NUM_MOD + i] = dom_stb[d];
        end
    end
    assign legal  = (want[0] <= want[1]) && (want[1] <= want[2]) && (want[1] <= want[3]);
    assign sel_wr = wr_en && (wr_addr == '0);

    assert_core_ge_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dom_stb[1] |-> dom_stb[0]);
    assert_fast_ge_pera_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dom_stb[2] |-> dom_stb[1]);
    assert_fast_ge_perb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dom_stb[3] |-> dom_stb[1]);
    assert_active_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_shift[0] <= act_shift[1]) && (act_shift[1] <= act_shift[2]) &&
        (act_shift[1] <= act_shift[3]));
    assert_gate_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en & ~stb_wide) == '0);
    assert_refuse_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !legal) |=> cfg_err);
    assert_accept_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && legal) |=> !cfg_err);
    assert_change_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_shift) |-> $past(at_wrap));
endmodule

bind bus_clk_prescaler bcp_checker #(
    .SEL_W  (SEL_W),
    .NUM_MOD(NUM_MOD),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_bcp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_word  (wr_data[WORD_W-1:0]),
    .dom_stb  (dom_stb),
    .mod_en   (mod_en),
    .cfg_err  (cfg_err),
    .act_shift(act_shift),
    .at_wrap  (at_wrap)
);

// File: tb/test_bus_clk_prescaler.sv
module test_bus_clk_prescaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  dom_stb;
    logic [31:0] mod_en;
    logic        cfg_err;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int       m_cnt;
    int       m_act[4];
    int       m_pend[4];
    bit       m_pendv;
    bit       m_err;
    bit [7:0] m_mask[4];

    bus_clk_prescaler i_bus_clk_prescaler (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dom_stb(dom_stb), .mod_en(mod_en), .cfg_err(cfg_err)
    );

    always #10ns clk = ~clk;

    function automatic int shift_of(input logic [15:0] w, input int d);
        return w[4*d+3] ? int'(w[4*d +: 3]) + 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pendv = 0; m_err = 0;
            for (int d = 0; d < 4; d++) begin
                m_act[d] = 0; m_pend[d] = 0; m_mask[d] = 8'hFF;
            end
        end else begin
            int  s[4];
            bit  ok;
            bit  acc;
            for (int d = 0; d < 4; d++) s[d] = shift_of(wr_data, d);
            ok  = (s[0] <= s[1]) && (s[1] <= s[2]) && (s[1] <= s[3]);
            acc = wr_en && wr_addr == 0 && ok;
            if (wr_en && wr_addr == 0) m_err = !ok;
            if (m_cnt == 255 && m_pendv) begin
                for (int d = 0; d < 4; d++) m_act[d] = m_pend[d];
                m_pendv = 0;
            end
            if (acc) begin
                for (int d = 0; d < 4; d++) m_pend[d] = s[d];
                m_pendv = 1;
            end
            if (wr_en && wr_addr >= 4) m_mask[wr_addr-4][wr_data[2:0]] = wr_data[15];
            m_cnt = (m_cnt + 1) % 256;
        end
    end

    // compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0]  e_stb;
            logic [31:0] e_mod;
            for (int d = 0; d < 4; d++) begin
                e_stb[d] = (m_cnt % (1 << m_act[d])) == 0;
                for (int i = 0; i < 8; i++) e_mod[8*d+i] = m_mask[d][i] & e_stb[d];
            end
            n_cmp += 3;
            if (dom_stb !== e_stb) begin
                n_bad++;
                $display("FAIL %s dom_stb actual=%b expected=%b phase=%0d", cur_req, dom_stb, e_stb, m_cnt);
            end
            if (mod_en !== e_mod) begin
                n_bad++;
                $display("FAIL %s mod_en actual=%h expected=%h", cur_req, mod_en, e_mod);
            end
            if (cfg_err !== m_err) begin
                n_bad++;
                $display("FAIL %s cfg_err actual=%b expected=%b", cur_req, cfg_err, m_err);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; idle(6);
        // mixed ladder: core /2, fast /4, per A /8, per B /4
        cur_req = "R2"; wr(3'd0, 16'h9A98); idle(300);
        // slowest setting on every domain
        cur_req = "R3"; wr(3'd0, 16'hFFFF); idle(560);
        // all divide enables clear: full rate
        cur_req = "R3"; wr(3'd0, 16'h0000); idle(300);
        // equal shifts: legal edge of the ordering rule
        cur_req = "R4"; wr(3'd0, 16'h9999); idle(20);
        // peripheral B faster than high-speed bus: refused
        cur_req = "R4"; wr(3'd0, 16'h0999); idle(300);
        // core slower than high-speed bus: refused, flag sticky
        cur_req = "R5"; wr(3'd0, 16'h000A); idle(30);
        wr(3'd0, 16'hBA99); idle(300);
        // rewrite before the wrap, then a write in the wrap cycle
        cur_req = "R6"; wr(3'd0, 16'h9999); idle(10);
        wr(3'd0, 16'hDCBA);
        while (m_cnt != 255) @(negedge clk);
        wr(3'd0, 16'h8888); idle(270);
        // single-bit mask edits with division active
        cur_req = "R8"; wr(3'd5, 16'h0003); idle(40);
        wr(3'd4, 16'h0000); wr(3'd4, 16'h0007); idle(20);
        wr(3'd7, 16'h0005); wr(3'd6, 16'h0001); idle(40);
        cur_req = "R7"; wr(3'd5, 16'h8003); wr(3'd4, 16'h8000); idle(40);
        // writes to unused addresses leave everything alone
        cur_req = "R8"; wr(3'd2, 16'hFFFF); wr(3'd1, 16'h0000); idle(300);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule